// File: doc/BRIEF.md
# VME Slave Cycle Responder

This block sits between the backplane of a VME crate and the register file of a home-built readout module. It watches the address, address-modifier, strobe, write and long-word lines. It compares the upper address bits with a programmable base, and it answers cycles aimed at its own 4 KB window with the full four-edge strobe/acknowledge handshake. Every backplane input first passes through a two-flop synchroniser. The cycle logic acts only on these synchronised copies.

Two cycle types are served. The first is the single 32-bit access: one word is read or written per address strobe. The second is a 64-bit block transfer. Here the address is given once, and each later data beat moves the next 64-bit entry. The data lines carry one half of the beat and the address lines together with the long-word line carry the other half. Inside the module the block drives a register-file port organised as 64-bit entries with one write enable per 32-bit half. It also drives a board-select output for a front-panel light. The acknowledge line is driven only as an enable with a constant low value, so several modules can share the wired line.

Top module: `vme_slave_resp`

## Requirements
- R1: While reset is high and right after it, the acknowledge enable, data and address drive enables, board select and both write enables are low.
- R2: A write with AM code 0x09 and long-word low, addressed inside the window (address bits 31..12 equal to the base), produces one single-cycle write pulse at entry A[11:3]. Address bit 2 picks the half: 0 gives enable bit 0 for bits 31..0, and 1 gives enable bit 1 for bits 63..32. Both halves of the write data carry D31..D0. The acknowledge enable rises afterwards.
- R3: A read with AM code 0x09 drives the addressed 32-bit half of entry A[11:3] onto D31..D0, with the data enable high while acknowledge is asserted.
- R4: Acknowledge is asserted only after both data strobes are low, and it stays asserted until both data strobes are high again.
- R5: A cycle whose address bits 31..12 differ from the base gives no acknowledge, no board select and no write.
- R6: Any AM code other than 0x08 and 0x09 is ignored: no acknowledge, no board select, no write.
- R7: AM code 0x09 with long-word high (a narrower than 32-bit access) is ignored in the same way.
- R8: In a block write (AM 0x08), each data beat writes the full entry with enable 2'b11. Bits 63..33 come from A31..A1, bit 32 from the long-word line level and bits 31..0 from D31..D0. The first beat goes to entry A[11:3] of the address phase and each later beat to the next entry.
- R9: In a block read, each beat drives entry bits 63..33 on the address outputs, bit 32 on the long-word output and bits 31..0 on the data outputs, with both drive enables high.
- R10: The entry index in block mode wraps from the last entry of the window to entry 0.
- R11: Board select is high from a decoded address phase until the address strobe is released.
- R12: When the address and data strobes are released at the same moment, the cycle ends cleanly and the next cycle is accepted.
- R13: The acknowledge output value is always low; only its enable toggles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_base | input | BASE_W | Window base, compared with address bits 31..12 |
| vme_as_n | input | 1 | Address strobe, active low |
| vme_ds_n | input | 2 | Data strobes, active low |
| vme_write_n | input | 1 | Low for a write cycle |
| vme_lword_n | input | 1 | Long-word line level |
| vme_am | input | 6 | Address-modifier code |
| vme_a_in | input | 31 | Address lines A31..A1 |
| vme_d_in | input | 32 | Data lines D31..D0 |
| vme_d_out | output | 32 | Read data for D31..D0 |
| vme_d_oe | output | 1 | Drive enable for the data lines |
| vme_a_out | output | 31 | Block-read data for A31..A1 |
| vme_lword_out | output | 1 | Block-read data bit for the long-word line |
| vme_a_oe | output | 1 | Drive enable for the address and long-word lines |
| vme_dtack_n_out | output | 1 | Acknowledge value, always low |
| vme_dtack_oe | output | 1 | Acknowledge drive enable |
| board_sel | output | 1 | Module is being addressed |
| rf_addr | output | PAIR_W | Register-file entry index |
| rf_we | output | 2 | Write enables, bit 0 low half, bit 1 high half |
| rf_wdata | output | 64 | Register-file write data |
| rf_rdata | input | 64 | Register-file read data for entry rf_addr |

## Verification
The release of the data strobes, which ends a beat, and the release of the address strobe, which ends the whole cycle, can reach the synchronised inputs in the same clock. The bench provokes this by raising both lines in one step at the end of a single write and at the end of a block transfer. Each time it then starts a fresh cycle a few clocks later. The case is judged correct when the acknowledge drops, board select falls, no stray write occurs, and the following cycle completes with the right data and entry index.

// File: rtl/vme_resp_pkg.sv
package vme_resp_pkg;

    localparam int VA_W = 32;
    localparam int VD_W = 32;
    localparam int ENT_W = 64;

    localparam logic [5:0] AM_SINGLE = 6'h09;
    localparam logic [5:0] AM_BLOCK  = 6'h08;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MISS,
        ST_WAIT_DS,
        ST_ACK,
        ST_TAIL
    } cyc_state_t;

    typedef struct packed {
        logic            as_n;
        logic [1:0]      ds_n;
        logic            write_n;
        logic            lword_n;
        logic [5:0]      am;
        logic [VA_W-1:1] addr;
        logic [VD_W-1:0] data;
    } bus_in_t;

    function automatic logic am_supported(input logic [5:0] am, input logic lword_n);
        return ((am == AM_SINGLE) && !lword_n) || (am == AM_BLOCK);
    endfunction

endpackage

// File: rtl/vme_in_sync.sv
module vme_in_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '1;
        end else begin
            stg[0] <= din;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/vme_decode.sv
module vme_decode
    import vme_resp_pkg::*;
#(
    parameter int BASE_W = 20
) (
    input  bus_in_t           s,
    input  logic [BASE_W-1:0] base,
    output logic              hit,
    output logic              is_block
);
    always_comb begin
        hit      = am_supported(s.am, s.lword_n) && (s.addr[VA_W-1 -: BASE_W] == base);
        is_block = (s.am == AM_BLOCK);
    end
endmodule

// File: rtl/vme_cycle_fsm.sv
module vme_cycle_fsm
    import vme_resp_pkg::*;
#(
    parameter int PAIR_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_in_t           s,
    input  logic              hit,
    input  logic              is_block,
    input  logic [ENT_W-1:0]  rf_rdata,
    output logic [PAIR_W-1:0] rf_addr,
    output logic [1:0]        rf_we,
    output logic [ENT_W-1:0]  rf_wdata,
    output logic [ENT_W-1:0]  dout,
    output logic              ack,
    output logic              rd_drv,
    output logic              blk_drv,
    output logic              sel
);
    cyc_state_t        state;
    logic              as_prev;
    logic              blk, rd, lane;
    logic [PAIR_W-1:0] pair;

    wire as_fall  = as_prev && !s.as_n;
    wire ds_low   = (s.ds_n == 2'b00);
    wire ds_high  = (s.ds_n == 2'b11);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            as_prev  <= 1'b1;
            blk      <= 1'b0;
            rd       <= 1'b0;
            lane     <= 1'b0;
            pair     <= '0;
            rf_we    <= 2'b00;
            rf_wdata <= '0;
            dout     <= '0;
        end else begin
            as_prev <= s.as_n;
            rf_we   <= 2'b00;
            unique case (state)
                ST_IDLE: begin
                    if (as_fall) begin
                        if (hit) begin
                            blk   <= is_block;
                            rd    <= s.write_n;
                            lane  <= s.addr[2];
                            pair  <= s.addr[PAIR_W+2:3];
                            state <= ST_WAIT_DS;
                        end else begin
                            state <= ST_MISS;
                        end
                    end
                end
                ST_MISS: begin
                    if (s.as_n) state <= ST_IDLE;
                end
                ST_WAIT_DS: begin
                    if (s.as_n) begin
                        state <= ST_IDLE;
                    end else if (ds_low) begin
                        if (rd) begin
                            if (blk)       dout <= rf_rdata;
                            else if (lane) dout <= {32'b0, rf_rdata[63:32]};
                            else           dout <= {32'b0, rf_rdata[31:0]};
                        end else if (blk) begin
                            rf_we    <= 2'b11;
                            rf_wdata <= {s.addr, s.lword_n, s.data};
                        end else begin
                            rf_we    <= lane ? 2'b10 : 2'b01;
                            rf_wdata <= {s.data, s.data};
                        end
                        state <= ST_ACK;
                    end
                end
                ST_ACK: begin
                    if (ds_high) begin
                        if (s.as_n) begin
                            state <= ST_IDLE;
                        end else if (blk) begin
                            pair  <= pair + 1'b1;
                            state <= ST_WAIT_DS;
                        end else begin
                            state <= ST_TAIL;
                        end
                    end
                end
                ST_TAIL: begin
                    if (s.as_n) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign rf_addr = pair;
    assign ack     = (state == ST_ACK);
    assign rd_drv  = ack && rd;
    assign blk_drv = ack && rd && blk;
    assign sel     = (state == ST_WAIT_DS) || (state == ST_ACK) || (state == ST_TAIL);
endmodule

// File: rtl/vme_slave_resp.sv
module vme_slave_resp
    import vme_resp_pkg::*;
#(
    parameter int BASE_W      = 20,
    parameter int SYNC_STAGES = 2,
    localparam int PAIR_W     = VA_W - BASE_W - 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BASE_W-1:0] cfg_base,
    input  logic              vme_as_n,
    input  logic [1:0]        vme_ds_n,
    input  logic              vme_write_n,
    input  logic              vme_lword_n,
    input  logic [5:0]        vme_am,
    input  logic [VA_W-1:1]   vme_a_in,
    input  logic [VD_W-1:0]   vme_d_in,
    output logic [VD_W-1:0]   vme_d_out,
    output logic              vme_d_oe,
    output logic [VA_W-1:1]   vme_a_out,
    output logic              vme_lword_out,
    output logic              vme_a_oe,
    output logic              vme_dtack_n_out,
    output logic              vme_dtack_oe,
    output logic              board_sel,
    output logic [PAIR_W-1:0] rf_addr,
    output logic [1:0]        rf_we,
    output logic [ENT_W-1:0]  rf_wdata,
    input  logic [ENT_W-1:0]  rf_rdata
);
    bus_in_t          raw_bus, syn_bus;
    logic             hit, is_block;
    logic [ENT_W-1:0] dout;

    always_comb begin
        raw_bus.as_n    = vme_as_n;
        raw_bus.ds_n    = vme_ds_n;
        raw_bus.write_n = vme_write_n;
        raw_bus.lword_n = vme_lword_n;
        raw_bus.am      = vme_am;
        raw_bus.addr    = vme_a_in;
        raw_bus.data    = vme_d_in;
    end

    vme_in_sync #(.W($bits(bus_in_t)), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (raw_bus),
        .dout (syn_bus)
    );

    vme_decode #(.BASE_W(BASE_W)) u_dec (
        .s        (syn_bus),
        .base     (cfg_base),
        .hit      (hit),
        .is_block (is_block)
    );

    vme_cycle_fsm #(.PAIR_W(PAIR_W)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .s        (syn_bus),
        .hit      (hit),
        .is_block (is_block),
        .rf_rdata (rf_rdata),
        .rf_addr  (rf_addr),
        .rf_we    (rf_we),
        .rf_wdata (rf_wdata),
        .dout     (dout),
        .ack      (vme_dtack_oe),
        .rd_drv   (vme_d_oe),
        .blk_drv  (vme_a_oe),
        .sel      (board_sel)
    );

    assign vme_d_out       = dout[VD_W-1:0];
    assign vme_lword_out   = dout[32];
    assign vme_a_out       = dout[ENT_W-1:33];
    assign vme_dtack_n_out = 1'b0;
endmodule

// File: rtl/vme_slave_resp_chk.sv
module vme_slave_resp_chk (
    input logic       clk,
    input logic       rst,
    input logic       vme_as_n,
    input logic [1:0] vme_ds_n,
    input logic       vme_dtack_oe,
    input logic       vme_d_oe,
    input logic       vme_a_oe,
    input logic       board_sel,
    input logic [1:0] rf_we
);
    // R11
    dtack_sel_chk: assert property (@(posedge clk) disable iff (rst)
        vme_dtack_oe |-> board_sel);

    // R2
    we_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (rf_we != 2'b00) |=> (rf_we == 2'b00));

    // R4
    dtack_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(vme_dtack_oe) |-> ($past(vme_ds_n, 2) == 2'b00));

    // R4
    dtack_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(vme_dtack_oe) |-> ($past(vme_ds_n, 2) == 2'b11));

    // R3
    rd_drive_chk: assert property (@(posedge clk) disable iff (rst)
        vme_d_oe |-> vme_dtack_oe);

    // R9
    blk_drive_chk: assert property (@(posedge clk) disable iff (rst)
        vme_a_oe |-> vme_d_oe);

    // R11
    sel_drop_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(board_sel) |-> $past(vme_as_n, 2));
endmodule

bind vme_slave_resp vme_slave_resp_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .vme_as_n     (vme_as_n),
    .vme_ds_n     (vme_ds_n),
    .vme_dtack_oe (vme_dtack_oe),
    .vme_d_oe     (vme_d_oe),
    .vme_a_oe     (vme_a_oe),
    .board_sel    (board_sel),
    .rf_we        (rf_we)
);

// File: tb/sim_vme_slave_resp.sv
module sim_vme_slave_resp;
    localparam int BASE_W = 20;
    localparam int PAIR_W = 32 - BASE_W - 3;
    localparam int NENT   = 1 << PAIR_W;
    localparam logic [BASE_W-1:0] BASE = 20'hABCDE;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              vme_as_n = 1'b1;
    logic [1:0]        vme_ds_n = 2'b11;
    logic              vme_write_n = 1'b1;
    logic              vme_lword_n = 1'b1;
    logic [5:0]        vme_am = 6'h3F;
    logic [31:1]       vme_a_in = '0;
    logic [31:0]       vme_d_in = '0;
    logic [31:0]       vme_d_out;
    logic              vme_d_oe;
    logic [31:1]       vme_a_out;
    logic              vme_lword_out;
    logic              vme_a_oe;
    logic              vme_dtack_n_out;
    logic              vme_dtack_oe;
    logic              board_sel;
    logic [PAIR_W-1:0] rf_addr;
    logic [1:0]        rf_we;
    logic [63:0]       rf_wdata;
    logic [63:0]       rf_rdata;

    logic [63:0] rfm [NENT];
    logic [63:0] expm [NENT];
    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    always #5 clk = ~clk;

    vme_slave_resp u0 (
        .clk(clk), .rst(rst), .cfg_base(BASE),
        .vme_as_n(vme_as_n), .vme_ds_n(vme_ds_n), .vme_write_n(vme_write_n),
        .vme_lword_n(vme_lword_n), .vme_am(vme_am), .vme_a_in(vme_a_in),
        .vme_d_in(vme_d_in), .vme_d_out(vme_d_out), .vme_d_oe(vme_d_oe),
        .vme_a_out(vme_a_out), .vme_lword_out(vme_lword_out), .vme_a_oe(vme_a_oe),
        .vme_dtack_n_out(vme_dtack_n_out), .vme_dtack_oe(vme_dtack_oe),
        .board_sel(board_sel), .rf_addr(rf_addr), .rf_we(rf_we),
        .rf_wdata(rf_wdata), .rf_rdata(rf_rdata)
    );

    function automatic logic [63:0] seed_val(input int i);
        return {32'h5EED0000 | 32'(i), 32'hC0DE0000 | 32'(i)};
    endfunction

    assign rf_rdata = rfm[rf_addr];

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NENT; i++) rfm[i] <= seed_val(i);
        end else begin
            if (rf_we[0]) rfm[rf_addr][31:0]  <= rf_wdata[31:0];
            if (rf_we[1]) rfm[rf_addr][63:32] <= rf_wdata[63:32];
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            errors = errors + 1;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // R13 compared on every clock
    always @(negedge clk) begin
        if (!rst && vme_dtack_n_out !== 1'b0) begin
            errors = errors + 1;
            $display("FAIL R13 dtack value act=%b exp=0", vme_dtack_n_out);
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s act=%h exp=%h", tag, act, expv);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic bus_idle();
        vme_as_n = 1'b1; vme_ds_n = 2'b11; vme_write_n = 1'b1;
        vme_lword_n = 1'b1; vme_am = 6'h3F; vme_a_in = '0; vme_d_in = '0;
    endtask

    task automatic wait_dtack(input bit level, output bit seen);
        seen = 0;
        for (int i = 0; i < 20 && !seen; i++) begin
            @(negedge clk);
            if (vme_dtack_oe == level) seen = 1;
        end
    endtask

    function automatic logic [31:1] addr_of(input logic [BASE_W-1:0] b, input int ent, input bit lane);
        logic [31:0] a;
        a = {b, 12'(ent) << 3} | (lane ? 32'h4 : 32'h0);
        return a[31:1];
    endfunction

    // single 32-bit cycle, expected to be answered
    task automatic single(input int ent, input bit lane, input bit wr, input logic [31:0] wd,
                          input bit joint, input string tag);
        bit seen;
        logic [31:0] ev;
        @(negedge clk);
        vme_a_in = addr_of(BASE, ent, lane); vme_am = 6'h09;
        vme_write_n = !wr; vme_lword_n = 1'b0;
        @(negedge clk); vme_as_n = 1'b0;
        @(negedge clk); vme_d_in = wd; vme_ds_n = 2'b00;
        wait_dtack(1'b1, seen);
        chk(seen, {tag, " acknowledge"}, 64'(vme_dtack_oe), 64'h1);
        chk(board_sel == 1'b1, "R11 select during cycle", 64'(board_sel), 64'h1);
        if (!wr) begin
            ev = lane ? expm[ent][63:32] : expm[ent][31:0];
            chk(vme_d_oe && vme_d_out == ev, {tag, " read data"}, 64'(vme_d_out), 64'(ev));
        end
        wait_cyc(3);
        chk(vme_dtack_oe == 1'b1, "R4 acknowledge held while strobes low", 64'(vme_dtack_oe), 64'h1);
        if (joint) begin
            vme_as_n = 1'b1; vme_ds_n = 2'b11;
        end else begin
            vme_as_n = 1'b1; @(negedge clk); vme_ds_n = 2'b11;
        end
        wait_dtack(1'b0, seen);
        chk(seen, "R4 acknowledge released", 64'(vme_dtack_oe), 64'h0);
        wait_cyc(3);
        chk(board_sel == 1'b0, "R11 select dropped", 64'(board_sel), 64'h0);
        if (wr) begin
            if (lane) expm[ent][63:32] = wd; else expm[ent][31:0] = wd;
        end
        chk(rfm[ent] == expm[ent], {tag, " entry contents"}, rfm[ent], expm[ent]);
        bus_idle();
        wait_cyc(2);
    endtask

    // cycle that must be ignored
    task automatic ignored(input logic [31:1] a, input logic [5:0] am, input bit lw, input int ent,
                           input string tag);
        bit bad;
        bad = 0;
        @(negedge clk);
        vme_a_in = a; vme_am = am; vme_write_n = 1'b0; vme_lword_n = lw;
        @(negedge clk); vme_as_n = 1'b0;
        @(negedge clk); vme_d_in = 32'hDEADBEEF; vme_ds_n = 2'b00;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (vme_dtack_oe || board_sel || rf_we != 2'b00) bad = 1;
        end
        chk(!bad, {tag, " no response"}, 64'(bad), 64'h0);
        bus_idle();
        wait_cyc(4);
        chk(rfm[ent] == expm[ent], {tag, " entry untouched"}, rfm[ent], expm[ent]);
    endtask

    function automatic logic [63:0] beat_val(input int k, input int salt);
        return {32'(k) * 32'h01010101 ^ 32'h80000001 ^ 32'(salt), 32'hB10C0000 + 32'(k) + 32'(salt)};
    endfunction

    task automatic block(input int ent0, input int beats, input bit wr, input int salt,
                         input bit joint, input string tag);
        bit seen;
        int e;
        logic [63:0] v;
        @(negedge clk);
        vme_a_in = addr_of(BASE, ent0, 1'b0); vme_am = 6'h08;
        vme_write_n = !wr; vme_lword_n = 1'b0;
        @(negedge clk); vme_as_n = 1'b0;
        wait_cyc(2);
        for (int k = 0; k < beats; k++) begin
            e = (ent0 + k) % NENT;
            v = beat_val(k, salt);
            if (wr) begin
                vme_a_in = v[63:33]; vme_lword_n = v[32]; vme_d_in = v[31:0];
            end
            @(negedge clk); vme_ds_n = 2'b00;
            wait_dtack(1'b1, seen);
            chk(seen, {tag, " beat acknowledge"}, 64'(vme_dtack_oe), 64'h1);
            if (!wr)
                chk(vme_a_oe && vme_d_oe && {vme_a_out, vme_lword_out, vme_d_out} == expm[e],
                    {tag, " R9 beat data"}, {vme_a_out, vme_lword_out, vme_d_out}, expm[e]);
            if (joint && k == beats - 1) begin
                vme_as_n = 1'b1; vme_ds_n = 2'b11;
            end else begin
                vme_ds_n = 2'b11;
            end
            wait_dtack(1'b0, seen);
            chk(seen, {tag, " R4 beat release"}, 64'(vme_dtack_oe), 64'h0);
            if (wr) begin
                expm[e] = v;
                wait_cyc(1);
                chk(rfm[e] == expm[e], {tag, " R8 entry written"}, rfm[e], expm[e]);
            end
        end
        vme_as_n = 1'b1;
        wait_cyc(4);
        chk(board_sel == 1'b0, "R11 select dropped after block", 64'(board_sel), 64'h0);
        bus_idle();
        wait_cyc(2);
    endtask

    initial begin
        for (int i = 0; i < NENT; i++) expm[i] = seed_val(i);
        wait_cyc(4);
        // R1
        chk(!vme_dtack_oe && !vme_d_oe && !vme_a_oe && !board_sel && rf_we == 2'b00,
            "R1 outputs in reset", {59'b0, vme_dtack_oe, vme_d_oe, vme_a_oe, board_sel, |rf_we}, 64'h0);
        rst = 1'b0;
        wait_cyc(3);
        chk(!vme_dtack_oe && !vme_d_oe && !board_sel && rf_we == 2'b00,
            "R1 outputs after reset", {60'b0, vme_dtack_oe, vme_d_oe, board_sel, |rf_we}, 64'h0);

        // R2 writes to both halves
        single(5, 1'b0, 1'b1, 32'h12345678, 1'b0, "R2 write low half");
        single(5, 1'b1, 1'b1, 32'h9ABCDEF0, 1'b0, "R2 write high half");
        single(300, 1'b1, 1'b1, 32'h0F0F0F0F, 1'b0, "R2 write entry 300");
        // R3 reads
        single(5, 1'b0, 1'b0, 32'h0, 1'b0, "R3 read low half");
        single(5, 1'b1, 1'b0, 32'h0, 1'b0, "R3 read high half");
        single(77, 1'b0, 1'b0, 32'h0, 1'b0, "R3 read seeded entry");

        // R5 foreign base, R6 unknown modifiers, R7 narrow access
        ignored(addr_of(BASE ^ 20'h00001, 9, 1'b0), 6'h09, 1'b0, 9, "R5 foreign base");
        ignored(addr_of(BASE, 9, 1'b0), 6'h0D, 1'b0, 9, "R6 modifier 0x0D");
        ignored(addr_of(BASE, 9, 1'b0), 6'h29, 1'b0, 9, "R6 modifier 0x29");
        ignored(addr_of(BASE, 9, 1'b0), 6'h09, 1'b1, 9, "R7 long-word high");

        // R8 block write, R9 block read, R10 wrap
        block(20, 4, 1'b1, 0, 1'b0, "R8 block write");
        block(20, 4, 1'b0, 0, 1'b0, "R9 block read");
        block(NENT - 2, 4, 1'b1, 7, 1'b0, "R10 wrap write");
        block(NENT - 2, 4, 1'b0, 0, 1'b0, "R10 wrap read");

        // R12 joint release, then immediate follow-up cycles
        single(40, 1'b0, 1'b1, 32'hA5A55A5A, 1'b1, "R12 joint release write");
        single(40, 1'b0, 1'b0, 32'h0, 1'b0, "R12 follow-up read");
        block(100, 3, 1'b1, 3, 1'b1, "R12 joint release block");
        single(100, 1'b1, 1'b0, 32'h0, 1'b0, "R12 read after block");
        chk(rfm[103] == expm[103], "R12 no stray beat write", rfm[103], expm[103]);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule